// File: doc/BRIEF.md
# Privilege Level and Access Fault Checker

This block sits in the memory and coprocessor-0 access path of a 64-bit core. From the exception-level, error-level, mode and coprocessor-0 enable bits of the status register, it works out the privilege level the core is running at. For each access it then flags two faults. The first is a coprocessor-0 unusable fault, for a coprocessor-0 access made outside kernel level while the enable bit is clear. The second is a granule-crossing alignment fault for a load or store.

The alignment rule is relaxed. Any misaligned access is allowed as long as it stays inside one 16-byte granule. The fault is raised only when the last byte of the access falls in a different granule from the first byte.

A separate flag reports whether a 64-bit operand is a properly sign-extended 32-bit word. Every output is registered, so results appear one clock after the inputs are sampled. The block raises no exception itself; the surrounding pipeline uses its outputs to do that.

Top module: `priv_access_check`

## Requirements
- R1: When exl_i or erl_i is 1, level_o is kernel (2'b00) whatever ksu_i holds.
- R2: With exl_i and erl_i both 0, ksu_i maps to level_o as follows: 2'b00 gives kernel (2'b00), 2'b01 gives supervisor (2'b01), and both 2'b10 and 2'b11 give user (2'b10).
- R3: A coprocessor-0 request (cop0_req_i=1) at supervisor or user level with cu0_i=0 sets cop_unusable_o. When this fault fires, ce_o reads 2'b00.
- R4: cop_unusable_o stays 0 in three cases: when the level is kernel, when cu0_i is 1, or when no coprocessor-0 request is made.
- R5: size_i gives the access width as 2'b00 = 1 byte, 2'b01 = 2, 2'b10 = 4 and 2'b11 = 8 bytes.
- R6: For a valid access, align_fault_o is 1 exactly when floor(addr/16) differs from floor((addr+width-1)/16). A misaligned access that stays within one granule does not fault.
- R7: align_fault_o is 0 whenever acc_valid_i is 0, whatever the address and size.
- R8: word_ok_o is 1 exactly when bits 63..32 of data_i all equal bit 31.
- R9: Outputs change one clock after their inputs are sampled. While rst is high, the outputs reset to level kernel with all flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exl_i | input | 1 | Exception-level bit of status |
| erl_i | input | 1 | Error-level bit of status |
| ksu_i | input | 2 | Mode field of status |
| cu0_i | input | 1 | Coprocessor-0 usable bit of status |
| cop0_req_i | input | 1 | A coprocessor-0 access is being made |
| acc_valid_i | input | 1 | A memory access is in progress |
| addr_i | input | 64 | Access address |
| size_i | input | 2 | Access size code |
| data_i | input | 64 | Operand for the sign-extension test |
| level_o | output | 2 | Privilege level: 00 kernel, 01 supervisor, 10 user |
| cop_unusable_o | output | 1 | Coprocessor-0 unusable fault |
| ce_o | output | 2 | Coprocessor number reported with the fault |
| align_fault_o | output | 1 | Access crosses a 16-byte granule |
| word_ok_o | output | 1 | Operand is a sign-extended 32-bit word |

## Verification
The level decode is tried with all four mode codes, first with both override bits clear and then with each override bit set alone. This separates the mode mapping from the override, and it shows that code 11 is treated as user and not as some fourth level.

Alignment is tried at three kinds of offset. Offsets that fit exactly against the end of a granule, such as a doubleword at 0x8, a word at 0xC and a halfword at 0xE, must pass. The same accesses shifted by one byte must fault. An odd-offset access well inside a granule must pass, which tells the 16-byte rule apart from natural alignment. An access near the top of the address space is also tried.

The sign-extension test uses values whose upper halves are all ones or all zeros, each paired with the matching and the mismatching state of bit 31. It also uses a value with one stray high bit.

// File: rtl/priv_pkg.sv
package priv_pkg;
  typedef enum logic [1:0] {
    LVL_KERNEL = 2'b00,
    LVL_SUPER  = 2'b01,
    LVL_USER   = 2'b10
  } priv_lvl_e;
endpackage

// File: rtl/priv_level_decode.sv
module priv_level_decode
  import priv_pkg::*;
(
  input  logic       exl,
  input  logic       erl,
  input  logic [1:0] ksu,
  output priv_lvl_e  lvl
);
  always_comb begin
    if (exl || erl) begin
      lvl = LVL_KERNEL;
    end else begin
      unique case (ksu)
        2'b00:   lvl = LVL_KERNEL;
        2'b01:   lvl = LVL_SUPER;
        default: lvl = LVL_USER;   // 10 and the undefined 11
      endcase
    end
  end
endmodule

// File: rtl/granule_cross_check.sv
module granule_cross_check #(
  parameter int ADDR_W    = 64,
  parameter int GRAN_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size_code,
  output logic              crosses
);
  localparam int SPAN_W = 4;
  logic [SPAN_W-1:0] last_off;   // width in bytes minus one
  logic [ADDR_W:0]   end_addr;

  always_comb begin
    last_off = SPAN_W'((1 << size_code) - 1);
    end_addr = {1'b0, addr} + {{(ADDR_W+1-SPAN_W){1'b0}}, last_off};
    crosses  = end_addr[ADDR_W:GRAN_LOG2] != {1'b0, addr[ADDR_W-1:GRAN_LOG2]};
  end
endmodule

// File: rtl/sext_word_check.sv
module sext_word_check #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic [DATA_W-1:0] value,
  output logic              is_word
);
  localparam int TOP_W = DATA_W - WORD_W + 1;
  logic [TOP_W-1:0] upper;
  always_comb begin
    upper   = value[DATA_W-1:WORD_W-1];
    is_word = (upper == '0) || (upper == '1);
  end
endmodule

// File: rtl/priv_access_check.sv
module priv_access_check
  import priv_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 64,
  parameter int WORD_W    = 32,
  parameter int GRAN_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exl_i,
  input  logic              erl_i,
  input  logic [1:0]        ksu_i,
  input  logic              cu0_i,
  input  logic              cop0_req_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [1:0]        level_o,
  output logic              cop_unusable_o,
  output logic [1:0]        ce_o,
  output logic              align_fault_o,
  output logic              word_ok_o
);
  priv_lvl_e lvl_c;
  logic      cross_c;
  logic      word_c;
  logic      cop_fault_c;

  priv_level_decode u_lvl (
    .exl (exl_i),
    .erl (erl_i),
    .ksu (ksu_i),
    .lvl (lvl_c)
  );

  granule_cross_check #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_gran (
    .addr      (addr_i),
    .size_code (size_i),
    .crosses   (cross_c)
  );

  sext_word_check #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_sext (
    .value   (data_i),
    .is_word (word_c)
  );

  assign cop_fault_c = cop0_req_i && (lvl_c != LVL_KERNEL) && !cu0_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_o        <= LVL_KERNEL;
      cop_unusable_o <= 1'b0;
      ce_o           <= 2'b00;
      align_fault_o  <= 1'b0;
      word_ok_o      <= 1'b0;
    end else begin
      level_o        <= lvl_c;
      cop_unusable_o <= cop_fault_c;
      ce_o           <= 2'b00;   // fault always names coprocessor 0
      align_fault_o  <= acc_valid_i && cross_c;
      word_ok_o      <= word_c;
    end
  end
endmodule

// File: rtl/priv_access_check_sva.sv
module priv_access_check_sva #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              exl_i,
  input logic              erl_i,
  input logic [1:0]        ksu_i,
  input logic              cu0_i,
  input logic              cop0_req_i,
  input logic              acc_valid_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic [DATA_W-1:0] data_i,
  input logic [1:0]        level_o,
  input logic              cop_unusable_o,
  input logic [1:0]        ce_o,
  input logic              align_fault_o,
  input logic              word_ok_o
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_kernel_override_r1: assert property (@(posedge clk) disable iff (rst)
    armed && $past(exl_i || erl_i) |-> level_o == 2'b00);

  p_undef_mode_user_r2: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!exl_i && !erl_i && ksu_i == 2'b11) |-> level_o == 2'b10);

  p_fault_not_kernel_r3: assert property (@(posedge clk) disable iff (rst)
    cop_unusable_o |-> (level_o != 2'b00) && (ce_o == 2'b00));

  p_cu0_blocks_fault_r4: assert property (@(posedge clk) disable iff (rst)
    armed && $past(cu0_i || !cop0_req_i) |-> !cop_unusable_o);

  p_byte_no_fault_r6: assert property (@(posedge clk) disable iff (rst)
    armed && $past(size_i == 2'b00) |-> !align_fault_o);

  p_idle_no_fault_r7: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(acc_valid_i) |-> !align_fault_o);

  p_ones_word_r8: assert property (@(posedge clk) disable iff (rst)
    armed && $past(data_i[DATA_W-1:31] == '1) |-> word_ok_o);

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (level_o == 2'b00) && !cop_unusable_o && !align_fault_o && !word_ok_o);
endmodule

bind priv_access_check priv_access_check_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (.*);

// File: tb/priv_access_check_tb.sv
module priv_access_check_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exl_i = 0, erl_i = 0, cu0_i = 0, cop0_req_i = 0, acc_valid_i = 0;
  logic [1:0]  ksu_i = 0, size_i = 0;
  logic [63:0] addr_i = 0, data_i = 0;
  logic [1:0]  level_o, ce_o;
  logic        cop_unusable_o, align_fault_o, word_ok_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  priv_access_check u_dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] ref_level(logic e, logic r, logic [1:0] k);
    if (e || r) return 2'b00;
    if (k == 2'b00) return 2'b00;
    if (k == 2'b01) return 2'b01;
    return 2'b10;
  endfunction

  function automatic logic ref_cross(logic [63:0] a, logic [1:0] s);
    logic [64:0] last;
    last = {1'b0, a} + 65'((64'd1 << s) - 1);
    return (last >> 4) != ({1'b0, a} >> 4);
  endfunction

  task automatic t_reset();
    rst = 1'b1; exl_i = 1; ksu_i = 2'b10; cop0_req_i = 1; acc_valid_i = 1;
    addr_i = 64'hF; size_i = 2'b11; data_i = 0;
    step();
    chk("R9 reset level", level_o, 2'b00);
    chk("R9 reset cop", cop_unusable_o, 0);
    chk("R9 reset align", align_fault_o, 0);
    chk("R9 reset word", word_ok_o, 0);
    rst = 1'b0; exl_i = 0; cop0_req_i = 0; acc_valid_i = 0;
    step();
  endtask

  task automatic t_levels();
    for (int o = 0; o < 3; o++) begin
      for (int k = 0; k < 4; k++) begin
        exl_i = (o == 1); erl_i = (o == 2); ksu_i = 2'(k);
        step();
        if (o == 0) chk("R2 mode map", level_o, ref_level(0, 0, 2'(k)));
        else        chk("R1 override", level_o, 2'b00);
      end
    end
    exl_i = 0; erl_i = 0;
  endtask

  task automatic t_latency();
    ksu_i = 2'b10; step();
    ksu_i = 2'b01;
    @(posedge clk); #0.5;
    chk("R9 one-cycle latency", level_o, 2'b01);
    #0.5;
  endtask

  task automatic t_cop();
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 2; c++) begin
        for (int q = 0; q < 2; q++) begin
          ksu_i = 2'(k); cu0_i = c[0]; cop0_req_i = q[0];
          step();
          if (q == 1 && c == 0 && k != 0) begin
            chk("R3 cop fault", cop_unusable_o, 1);
            chk("R3 ce value", ce_o, 2'b00);
          end else begin
            chk("R4 no cop fault", cop_unusable_o, 0);
          end
        end
      end
    end
    exl_i = 1; ksu_i = 2'b10; cu0_i = 0; cop0_req_i = 1;
    step();
    chk("R4 exl kernel no cop fault", cop_unusable_o, 0);
    exl_i = 0; cop0_req_i = 0;
  endtask

  task automatic t_align_one(logic [63:0] a, logic [1:0] s, logic exp_f);
    addr_i = a; size_i = s; acc_valid_i = 1;
    step();
    chk("R6 granule cross", align_fault_o, exp_f);
    chk("R6 model agrees", align_fault_o, ref_cross(a, s));
  endtask

  task automatic t_align();
    t_align_one(64'h1008, 2'b11, 0);   // R5 8 bytes fits
    t_align_one(64'h1009, 2'b11, 1);
    t_align_one(64'h100C, 2'b10, 0);   // R5 4 bytes fits
    t_align_one(64'h100D, 2'b10, 1);
    t_align_one(64'h100E, 2'b01, 0);   // R5 2 bytes fits
    t_align_one(64'h100F, 2'b01, 1);
    t_align_one(64'h100F, 2'b00, 0);   // R5 1 byte never crosses
    t_align_one(64'h1003, 2'b11, 0);   // odd offset inside granule
    t_align_one(64'hFFFF_FFFF_FFFF_FFFC, 2'b11, 1);
    for (int s = 0; s < 4; s++) begin
      for (int off = 0; off < 16; off++) begin
        t_align_one(64'h2000 + 64'(off), 2'(s), (off + (1 << s) - 1) > 15);
      end
    end
  endtask

  task automatic t_idle();
    acc_valid_i = 0; addr_i = 64'h100F; size_i = 2'b11;
    step();
    chk("R7 idle no fault", align_fault_o, 0);
    acc_valid_i = 1;
    step();
    chk("R7 same access valid faults", align_fault_o, 1);
    acc_valid_i = 0;
  endtask

  task automatic t_word();
    data_i = 64'hFFFF_FFFF_8000_0000; step(); chk("R8 neg word", word_ok_o, 1);
    data_i = 64'h0000_0000_7FFF_FFFF; step(); chk("R8 pos word", word_ok_o, 1);
    data_i = 64'h0000_0000_8000_0000; step(); chk("R8 bad zero-ext", word_ok_o, 0);
    data_i = 64'hFFFF_FFFF_7FFF_FFFF; step(); chk("R8 bad ones", word_ok_o, 0);
    data_i = 64'h0001_0000_0000_0000; step(); chk("R8 stray bit", word_ok_o, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_levels();
    t_latency();
    t_cop();
    t_align();
    t_idle();
    t_word();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule